// File: doc/BRIEF.md
# Refcounted Wake Lock Controller

This block sits in front of a register region that a power controller may power down. Register-access clients send get and put pulses, each with the address they are about to touch. Only addresses inside a fixed window count. The block keeps a reference count of in-window holders. When the first holder arrives it raises a wake request toward the power controller and waits for that controller to acknowledge. When the last holder leaves it does not drop the request at once. It waits a hold delay first, so that a burst of accesses close together shares one handshake.

A level enable arms the mechanism. Turning it off runs any pending release straight away and then clears all state. The block reports whether the lock is currently held, and it keeps sticky flags for handshake timeouts, unmatched puts and count saturation. A write strobe clears these flags. All delays are counted in time units produced by a clock prescaler.

Top module: `wake_lock_ctrl`

## Requirements
- R1: A get or put changes the count only when its address lies between 0x60000 and 0x7FFFF inclusive. Addresses 0x5FFFF and 0x80000 have no effect.
- R2: While `lock_en` is low, gets and puts leave `ref_count` at 0 and `wake_req` stays low.
- R3: A get on a nonzero count adds one to `ref_count` and starts no new handshake.
- R4: A get on a zero count sets `ref_count` to 1. If the lock is not taken, the get raises `wake_req`, and `lock_taken` goes high only after `wake_ack` is seen high.
- R5: A get that arrives during the hold delay cancels the pending release and reuses the held lock. It does not wait for `wake_ack`, so no timeout can follow even when the acknowledge is low.
- R6: The wait for `wake_ack` high lasts at most ACK_TMO time units. On expiry `err_timeout` is set, `lock_taken` stays low and `wake_req` stays high.
- R7: A put that brings the count to zero starts a hold of HOLD_UNITS time units. When the hold ends, `wake_req` falls, and `lock_taken` falls once `wake_ack` is seen low.
- R8: A put on a zero count leaves `ref_count` at 0 and sets `err_underflow`.
- R9: When `lock_en` falls during a hold, the release runs at once without waiting out the hold. Disabling always ends with `ref_count` 0, `lock_taken` 0 and `wake_req` 0. Enabling starts with the lock not taken.
- R10: A get and a put in the same cycle cancel each other on a nonzero count. On a zero count the get is handled first, so the lock is acquired and a hold starts.
- R11: `ref_count` saturates at 255. A get at 255 keeps the count at 255 and sets `err_overflow`.
- R12: `err_timeout`, `err_underflow` and `err_overflow` stay set until an `err_clr` pulse. If a new error event arrives in the same cycle as the pulse, the event wins.
- R13: If `wake_ack` stays high for ACK_TMO units after the request falls, `err_timeout` is set and `lock_taken` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Arms the mechanism (level) |
| get_vld | input | 1 | Get pulse |
| get_addr | input | ADDR_W | Address for the get |
| put_vld | input | 1 | Put pulse |
| put_addr | input | ADDR_W | Address for the put |
| err_clr | input | 1 | Clears the sticky error flags |
| wake_ack | input | 1 | Acknowledge from the power controller |
| wake_req | output | 1 | Wake request to the power controller |
| lock_taken | output | 1 | The lock is acknowledged and held |
| ref_count | output | CNT_W | Current reference count |
| err_timeout | output | 1 | Sticky: a handshake timed out |
| err_underflow | output | 1 | Sticky: a put arrived on a zero count |
| err_overflow | output | 1 | Sticky: a get arrived on a saturated count |

## Verification
The bench probes both edges of the address window. A design with an off-by-one compare would count 0x5FFFF or 0x80000, or would miss 0x7FFFF. To test reuse during the hold, the bench holds the acknowledge low while a get arrives in the hold. A design that starts a new handshake there would raise a timeout. It also turns the enable off in the middle of a hold and checks that the request falls within a few cycles; a design that waits out the full hold would still be requesting. Further cases cover a get and a put in the same cycle on a zero count, a put with no matching get, a stuck acknowledge in both the acquire and the release wait, and 256 gets in a row. The last case catches a counter that wraps instead of saturating.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

    typedef enum logic [2:0] {
        S_OFF  = 3'd0,
        S_RUN  = 3'd1,
        S_ACQ  = 3'd2,
        S_HOLD = 3'd3,
        S_REL  = 3'd4
    } wlk_state_e;

    typedef struct packed {
        logic ovf;
        logic udf;
    } wlk_cnt_evt_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_GET  = 0;
    localparam int PORT_PUT  = 1;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wlk_window.sv
module wlk_window #(
    parameter int                 ADDR_W = 32,
    parameter int                 NPORT  = 2,
    parameter logic [ADDR_W-1:0]  WIN_LO = 'h60000,
    parameter logic [ADDR_W-1:0]  WIN_HI = 'h7FFFF
) (
    input  logic [NPORT-1:0]             vld,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    output logic [NPORT-1:0]             hit
);
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign hit[i] = vld[i] && (addr[i] >= WIN_LO) && (addr[i] <= WIN_HI);
    end
endmodule

// File: rtl/wlk_timer.sv
module wlk_timer #(
    parameter int PRESCALE = 1000,
    parameter int UNIT_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic [UNIT_W-1:0] units
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            units <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && (units != '1))
                units <= units + 1'b1;
        end
    end
endmodule

// File: rtl/wlk_refcnt.sv
module wlk_refcnt
    import wlk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output wlk_cnt_evt_t     evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        cnt_nxt = cnt_q;
        evt     = '0;
        if (clr) begin
            cnt_nxt = '0;
        end else if (inc && !dec) begin
            if (cnt_q == CNT_MAX) evt.ovf = 1'b1;
            else                  cnt_nxt = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q == '0) evt.udf = 1'b1;
            else             cnt_nxt = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !clr && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/wake_lock_ctrl.sv
module wake_lock_ctrl
    import wlk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] WIN_LO     = 'h60000,
    parameter logic [ADDR_W-1:0] WIN_HI     = 'h7FFFF,
    parameter int                CNT_W      = 8,
    parameter int                PRESCALE   = 1000,
    parameter int                ACK_TMO    = 5,
    parameter int                HOLD_UNITS = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_en,
    input  logic              get_vld,
    input  logic [ADDR_W-1:0] get_addr,
    input  logic              put_vld,
    input  logic [ADDR_W-1:0] put_addr,
    input  logic              err_clr,
    input  logic              wake_ack,
    output logic              wake_req,
    output logic              lock_taken,
    output logic [CNT_W-1:0]  ref_count,
    output logic              err_timeout,
    output logic              err_underflow,
    output logic              err_overflow
);
    localparam int UNIT_LIM = max_of(ACK_TMO, HOLD_UNITS);
    localparam int UNIT_W   = $clog2(UNIT_LIM + 1);
    localparam logic [UNIT_W-1:0] TMO_U  = UNIT_W'(ACK_TMO);
    localparam logic [UNIT_W-1:0] HOLD_U = UNIT_W'(HOLD_UNITS);

    wlk_state_e                   state_q, state_d;
    logic                         req_q, req_d;
    logic                         taken_q, taken_d;
    logic                         err_to_q, err_uf_q, err_ov_q;
    logic                         to_evt;
    logic                         tmr_restart;
    logic                         cnt_clr;
    logic                         live;
    logic                         inc, dec;
    logic                         zero_get, nxt_zero;
    logic [NUM_PORTS-1:0]         port_vld, port_hit;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] port_addr;
    logic [CNT_W-1:0]             cnt_q, cnt_nxt;
    wlk_cnt_evt_t                 cnt_evt;
    logic [UNIT_W-1:0]            units;

    assign port_vld[PORT_GET]  = get_vld;
    assign port_vld[PORT_PUT]  = put_vld;
    assign port_addr[PORT_GET] = get_addr;
    assign port_addr[PORT_PUT] = put_addr;

    wlk_window #(
        .ADDR_W (ADDR_W),
        .NPORT  (NUM_PORTS),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_window (
        .vld  (port_vld),
        .addr (port_addr),
        .hit  (port_hit)
    );

    assign live = (state_q != S_OFF) && lock_en;
    assign inc  = live && port_hit[PORT_GET];
    assign dec  = live && port_hit[PORT_PUT];

    wlk_refcnt #(.CNT_W(CNT_W)) u_refcnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .dec     (dec),
        .clr     (cnt_clr),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .evt     (cnt_evt)
    );

    wlk_timer #(.PRESCALE(PRESCALE), .UNIT_W(UNIT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .units   (units)
    );

    assign zero_get = inc && (cnt_q == '0);
    assign nxt_zero = (cnt_nxt == '0);

    always_comb begin
        state_d     = state_q;
        req_d       = req_q;
        taken_d     = taken_q;
        to_evt      = 1'b0;
        tmr_restart = 1'b0;
        cnt_clr     = 1'b0;
        unique case (state_q)
            S_OFF: begin
                if (lock_en) begin
                    state_d = S_RUN;
                    taken_d = 1'b0;
                end
            end
            S_RUN: begin
                if (!lock_en) begin
                    state_d = S_OFF; req_d = 1'b0; taken_d = 1'b0; cnt_clr = 1'b1;
                end else if (zero_get && !taken_q) begin
                    state_d = S_ACQ; req_d = 1'b1; tmr_restart = 1'b1;
                end else if (nxt_zero && (zero_get || cnt_q != '0)) begin
                    state_d = S_HOLD; tmr_restart = 1'b1;
                end
            end
            S_ACQ: begin
                if (!lock_en) begin
                    state_d = S_OFF; req_d = 1'b0; taken_d = 1'b0; cnt_clr = 1'b1;
                end else if (wake_ack || units == TMO_U) begin
                    taken_d     = wake_ack;
                    to_evt      = !wake_ack;
                    state_d     = nxt_zero ? S_HOLD : S_RUN;
                    tmr_restart = 1'b1;
                end
            end
            S_HOLD: begin
                if (!lock_en || (!inc && units == HOLD_U)) begin
                    state_d = S_REL; req_d = 1'b0; tmr_restart = 1'b1;
                end else if (inc) begin
                    tmr_restart = 1'b1;
                    if (!taken_q)      state_d = S_ACQ;
                    else if (nxt_zero) state_d = S_HOLD;
                    else               state_d = S_RUN;
                end
            end
            S_REL: begin
                if (!wake_ack || units == TMO_U) begin
                    to_evt      = wake_ack;
                    taken_d     = wake_ack ? taken_q : 1'b0;
                    tmr_restart = 1'b1;
                    if (!lock_en) begin
                        state_d = S_OFF; taken_d = 1'b0; cnt_clr = 1'b1;
                    end else if (!nxt_zero && !taken_d) begin
                        state_d = S_ACQ; req_d = 1'b1;
                    end else begin
                        state_d = S_RUN;
                    end
                end
            end
            default: begin
                state_d = S_OFF; req_d = 1'b0; taken_d = 1'b0; cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OFF;
            req_q   <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
            taken_q <= taken_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_to_q <= 1'b0;
            err_uf_q <= 1'b0;
            err_ov_q <= 1'b0;
        end else begin
            if (to_evt)           err_to_q <= 1'b1;
            else if (err_clr)     err_to_q <= 1'b0;
            if (cnt_evt.udf)      err_uf_q <= 1'b1;
            else if (err_clr)     err_uf_q <= 1'b0;
            if (cnt_evt.ovf)      err_ov_q <= 1'b1;
            else if (err_clr)     err_ov_q <= 1'b0;
        end
    end

    assign wake_req      = req_q;
    assign lock_taken    = taken_q;
    assign ref_count     = cnt_q;
    assign err_timeout   = err_to_q;
    assign err_underflow = err_uf_q;
    assign err_overflow  = err_ov_q;

    // R2
    off_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OFF) |-> !req_q);

    // R4
    taken_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(taken_q) |-> ($past(state_q) == S_ACQ && $past(wake_ack)));

    // R7
    taken_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(taken_q) |-> (($past(state_q) == S_REL && !$past(wake_ack)) || !$past(lock_en)));

    // R12
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_to_q && !err_clr) |=> err_to_q);

    // R12
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_uf_q && !err_clr) |=> err_uf_q);
endmodule

// File: tb/wake_lock_ctrl_tb.sv
module wake_lock_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lock_en = 1'b0;
    logic              get_vld = 1'b0;
    logic [ADDR_W-1:0] get_addr = '0;
    logic              put_vld = 1'b0;
    logic [ADDR_W-1:0] put_addr = '0;
    logic              err_clr = 1'b0;
    logic              wake_ack;
    logic              wake_req;
    logic              lock_taken;
    logic [CNT_W-1:0]  ref_count;
    logic              err_timeout, err_underflow, err_overflow;

    int checks = 0;
    int fails  = 0;

    // ack model: 0 = follows request two cycles late, 1 = stuck low, 2 = stuck high
    int   ack_mode = 0;
    logic ack_d1 = 1'b0, ack_d2 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        ack_d1 <= wake_req;
        ack_d2 <= ack_d1;
    end
    assign wake_ack = (ack_mode == 0) ? ack_d2 : (ack_mode == 2);

    wake_lock_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRESCALE(2), .ACK_TMO(5), .HOLD_UNITS(50)
    ) u_dut (
        .clk(clk), .rst(rst), .lock_en(lock_en),
        .get_vld(get_vld), .get_addr(get_addr),
        .put_vld(put_vld), .put_addr(put_addr),
        .err_clr(err_clr), .wake_ack(wake_ack),
        .wake_req(wake_req), .lock_taken(lock_taken), .ref_count(ref_count),
        .err_timeout(err_timeout), .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    typedef struct packed {
        logic [1:0]  op;     // bit0 get, bit1 put
        logic [31:0] addr;
        logic [7:0]  waitc;
        logic [7:0]  cnt;
        logic        req;
        logic        tk;
        logic        to;
        logic        uf;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 32'h00060000, 8'd6,   8'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 first get acquires
        '{2'd1, 32'h0005FFFF, 8'd3,   8'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 below window
        '{2'd1, 32'h0007FFFF, 8'd3,   8'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 top edge, R3 increment
        '{2'd2, 32'h00080000, 8'd3,   8'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 above window
        '{2'd3, 32'h00070000, 8'd3,   8'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 cancel on nonzero
        '{2'd2, 32'h00070000, 8'd3,   8'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // put decrements
        '{2'd2, 32'h00060000, 8'd6,   8'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 hold pending
        '{2'd1, 32'h00060000, 8'd3,   8'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 get during hold
        '{2'd2, 32'h00060000, 8'd3,   8'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 hold restarts
        '{2'd0, 32'h00000000, 8'd110, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 released
        '{2'd2, 32'h00060000, 8'd2,   8'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 underflow
        '{2'd3, 32'h00060000, 8'd6,   8'd0, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 get first on zero, R12 sticky
        '{2'd0, 32'h00000000, 8'd120, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1}  // R10 hold then release
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input int n);
        @(negedge clk);
        get_vld  = op[0];
        put_vld  = op[1];
        get_addr = addr;
        put_addr = addr;
        @(negedge clk);
        get_vld = 1'b0;
        put_vld = 1'b0;
        wait_cyc(n);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // reset state
        chk("reset", "req", wake_req, 0);
        chk("reset", "taken", lock_taken, 0);
        chk("reset", "count", ref_count, 0);
        chk("reset", "flags", {err_timeout, err_underflow, err_overflow}, 0);

        // R2: disabled ignores gets
        run_op(2'd1, 32'h60000, 6);
        chk("R2", "count", ref_count, 0);
        chk("R2", "req", wake_req, 0);

        lock_en = 1'b1;
        wait_cyc(2);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].op, VECS[i].addr, int'(VECS[i].waitc));
            chk($sformatf("row%0d", i), "count", ref_count, VECS[i].cnt);
            chk($sformatf("row%0d", i), "req", wake_req, VECS[i].req);
            chk($sformatf("row%0d", i), "taken", lock_taken, VECS[i].tk);
            chk($sformatf("row%0d", i), "timeout", err_timeout, VECS[i].to);
            chk($sformatf("row%0d", i), "underflow", err_underflow, VECS[i].uf);
        end

        // R12: clear pulse drops underflow flag
        pulse_clr();
        chk("R12", "underflow cleared", err_underflow, 0);

        // R5: reuse in hold with ack held low, no timeout may follow
        run_op(2'd1, 32'h60000, 6);
        run_op(2'd2, 32'h60000, 6);
        ack_mode = 1;
        run_op(2'd1, 32'h60000, 20);
        chk("R5", "timeout", err_timeout, 0);
        chk("R5", "taken", lock_taken, 1);
        chk("R5", "count", ref_count, 1);
        ack_mode = 0;
        run_op(2'd2, 32'h60000, 120);
        chk("R7", "req after release", wake_req, 0);
        chk("R7", "taken after release", lock_taken, 0);

        // R6: acquire timeout
        ack_mode = 1;
        run_op(2'd1, 32'h60000, 4);
        chk("R6", "no early timeout", err_timeout, 0);
        chk("R6", "req during wait", wake_req, 1);
        wait_cyc(11);
        chk("R6", "timeout", err_timeout, 1);
        chk("R6", "taken", lock_taken, 0);
        chk("R6", "req held", wake_req, 1);
        chk("R6", "count", ref_count, 1);
        pulse_clr();
        chk("R12", "timeout cleared", err_timeout, 0);
        run_op(2'd2, 32'h60000, 120);
        chk("R7", "req after timeout path", wake_req, 0);
        ack_mode = 0;

        // R13: release timeout
        run_op(2'd1, 32'h60000, 6);
        ack_mode = 2;
        run_op(2'd2, 32'h60000, 120);
        chk("R13", "timeout", err_timeout, 1);
        chk("R13", "taken kept", lock_taken, 1);
        chk("R13", "req", wake_req, 0);
        ack_mode = 0;
        pulse_clr();
        lock_en = 1'b0;
        wait_cyc(3);
        lock_en = 1'b1;
        wait_cyc(3);
        chk("R9", "enable marks not taken", lock_taken, 0);

        // R9: disable during hold flushes release
        run_op(2'd1, 32'h60000, 6);
        run_op(2'd2, 32'h60000, 6);
        chk("R9", "in hold req", wake_req, 1);
        lock_en = 1'b0;
        wait_cyc(8);
        chk("R9", "req after flush", wake_req, 0);
        chk("R9", "taken after flush", lock_taken, 0);
        chk("R9", "timeout after flush", err_timeout, 0);
        lock_en = 1'b1;
        wait_cyc(3);

        // R9: disable with holders clears count
        run_op(2'd1, 32'h60000, 0);
        run_op(2'd1, 32'h60000, 6);
        chk("R3", "two holders", ref_count, 2);
        lock_en = 1'b0;
        wait_cyc(3);
        chk("R9", "count cleared", ref_count, 0);
        chk("R9", "req low", wake_req, 0);
        chk("R9", "taken low", lock_taken, 0);
        lock_en = 1'b1;
        wait_cyc(3);

        // R11: saturation
        @(negedge clk);
        get_vld  = 1'b1;
        get_addr = 32'h60000;
        repeat (256) @(negedge clk);
        get_vld = 1'b0;
        wait_cyc(6);
        chk("R11", "count saturated", ref_count, 255);
        chk("R11", "overflow", err_overflow, 1);
        pulse_clr();
        chk("R12", "overflow cleared", err_overflow, 0);
        lock_en = 1'b0;
        wait_cyc(3);

        finish_run();
    end
endmodule